// File: doc/BRIEF.md
# Memoryless Coordinate Pattern Generator

This block is a raster pixel source that produces a colour for every pixel position of a frame without any frame store. It holds a horizontal and a vertical coordinate counter that advance one pixel per enable pulse. The red, green and blue values for the current position are computed directly from the two coordinates. Wide frames are scanned left to right, and lines are scanned top to bottom.

A 3-bit selector chooses one of eight coordinate functions. Some produce grey images, with the same value on all channels, and others produce coloured images. A new selector value is taken only when a frame starts, so a frame is never drawn with two functions. Every channel carries the low bits of its arithmetic result, so sums, differences and products wrap. The display timing and any scaling sit downstream and use the exposed coordinates and the frame-start pulse.

Top module: `pattern_gen`

## Requirements
- R1: While reset is asserted, both coordinates, all three colour channels, the valid flag and the frame-start pulse are 0, and the active function is function 0.
- R2: On each cycle with `pix_en` high, `px_x` advances by one. When it is at H-1 (319 by default) it returns to 0 and `px_y` advances by one.
- R3: On a cycle with `pix_en` low, both coordinates keep their values, and `pix_valid` is low in the following cycle.
- R4: When an enabled pixel at (H-1, V-1) is consumed, the coordinates become (0, 0) and `frame_start` is high for exactly that one cycle. At all other times `frame_start` is low.
- R5: For each enabled pixel (x, y), the colour appears on the outputs one cycle after the coordinates showed (x, y), and `pix_valid` is high in that cycle. When no pixel was enabled, the colour outputs hold their values.
- R6: `mode_sel` is sampled only at the enabled pixel that closes a frame. That sample governs every pixel of the next frame. Changes at any other time have no effect on the colours.
- R7: Each channel is 8 bits wide and is the low 8 bits (modulo 256) of its result. Function 0 gives red=x, green=y, blue=x^y. Function 3 gives red=x, green=y, blue=0.
- R8: Function 1 gives red=x and green=blue=x+y. Function 2 gives red=x and green=blue=x*y.
- R9: Function 4 gives all channels x*x+y*y. Function 6 gives all channels x*x-y*y, taken modulo 256.
- R10: Function 5 gives red=x+y, green=x-y (modulo 256) and blue=x^y. Function 7 gives all channels max(x, y).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_en | input | 1 | Consume one pixel this cycle |
| mode_sel | input | 3 | Requested coordinate function |
| px_x | output | 9 | Current horizontal coordinate |
| px_y | output | 8 | Current vertical coordinate |
| frame_start | output | 1 | One-cycle pulse as coordinates return to (0,0) |
| red | output | 8 | Red channel of the last enabled pixel |
| grn | output | 8 | Green channel of the last enabled pixel |
| blu | output | 8 | Blue channel of the last enabled pixel |
| pix_valid | output | 1 | Colour outputs hold a new pixel |

## Verification
Two events can fall on the same clock edge. One is the colour computation for the last pixel of a frame, which must still use the old function. The other is the switch of the active function, which happens together with the coordinate wrap. The bench randomises `mode_sel` on nearly every cycle. On the closing pixel of each frame it forces a planned function, so that all eight functions each govern a whole frame. The colour of the final pixel is judged against the previous frame's function. The first pixel of the new frame is judged against the newly sampled function. The bench uses a short frame height so that many frames fit in the run.

// File: rtl/pattern_gen.sv
module pattern_gen #(
  parameter int H  = 320,
  parameter int V  = 240,
  parameter int CW = 8,
  localparam int XW = $clog2(H),
  localparam int YW = $clog2(V)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic [2:0]    mode_sel,
  output logic [XW-1:0] px_x,
  output logic [YW-1:0] px_y,
  output logic          frame_start,
  output logic [CW-1:0] red,
  output logic [CW-1:0] grn,
  output logic [CW-1:0] blu,
  output logic          pix_valid
);
  localparam int PW = 2*XW + 2;

  logic [2:0]    act_mode;
  logic          last_x, last_y, wrap;
  logic [PW-1:0] xe, ye, sum, dif, prd, sqs, sqd, big;
  logic [PW-1:0] r_c, g_c, b_c;

  assign last_x = px_x == XW'(H-1);
  assign last_y = px_y == YW'(V-1);
  assign wrap   = pix_en && last_x && last_y;

  assign xe  = PW'(px_x);
  assign ye  = PW'(px_y);
  assign sum = xe + ye;
  assign dif = xe - ye;
  assign prd = xe * ye;
  assign sqs = xe*xe + ye*ye;
  assign sqd = xe*xe - ye*ye;
  assign big = (xe > ye) ? xe : ye;

  always_comb begin
    r_c = xe; g_c = ye; b_c = xe ^ ye;
    case (act_mode)
      3'd1: begin g_c = sum; b_c = sum; end
      3'd2: begin g_c = prd; b_c = prd; end
      3'd3: b_c = '0;
      3'd4: begin r_c = sqs; g_c = sqs; b_c = sqs; end
      3'd5: begin r_c = sum; g_c = dif; end
      3'd6: begin r_c = sqd; g_c = sqd; b_c = sqd; end
      3'd7: begin r_c = big; g_c = big; b_c = big; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      px_x        <= '0;
      px_y        <= '0;
      act_mode    <= '0;
      frame_start <= 1'b0;
      pix_valid   <= 1'b0;
      red         <= '0;
      grn         <= '0;
      blu         <= '0;
    end else begin
      frame_start <= wrap;
      pix_valid   <= pix_en;
      if (pix_en) begin
        red  <= r_c[CW-1:0];
        grn  <= g_c[CW-1:0];
        blu  <= b_c[CW-1:0];
        px_x <= last_x ? '0 : px_x + 1'b1;
        if (last_x) px_y <= last_y ? '0 : px_y + 1'b1;
      end
      if (wrap) act_mode <= mode_sel;
    end
  end
endmodule

// File: rtl/pattern_gen_chk.sv
module pattern_gen_chk #(
  parameter int H = 320,
  parameter int V = 240,
  localparam int XW = $clog2(H),
  localparam int YW = $clog2(V)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic [XW-1:0] px_x,
  input logic [YW-1:0] px_y,
  input logic          frame_start,
  input logic          pix_valid,
  input logic [2:0]    act_mode
);
  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    px_x <= XW'(H-1) && px_y <= YW'(V-1));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && px_x != XW'(H-1) |=> px_x == $past(px_x) + 1'b1 && $stable(px_y));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(px_x) && $stable(px_y) && !pix_valid);
  p_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> px_x == '0 && px_y == '0);
  p_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  p_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> pix_valid);
  p_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_mode) |-> frame_start);
endmodule

bind pattern_gen pattern_gen_chk #(.H(H), .V(V)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .px_x(px_x), .px_y(px_y),
  .frame_start(frame_start), .pix_valid(pix_valid), .act_mode(act_mode));

// File: tb/pattern_gen_test.sv
module pattern_gen_test;
  localparam int CLK_NS = 10;
  localparam int H = 320;
  localparam int V = 16;
  localparam int XW = $clog2(H);
  localparam int YW = $clog2(V);

  logic clk = 0, rst_n = 0, pix_en = 0;
  logic [2:0] mode_sel = 0;
  logic [XW-1:0] px_x;
  logic [YW-1:0] px_y;
  logic frame_start, pix_valid;
  logic [7:0] red, grn, blu;

  int n_chk = 0, n_bad = 0;
  int mx = 0, my = 0, mmode = 0, plan = 1, frames = 0, cyc = 0;
  int er = 0, eg = 0, eb = 0, ev = 0, efs = 0, emode = 0;
  bit stale = 0;

  pattern_gen #(.H(H), .V(V)) uut (.*);

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (x=%0d y=%0d)", req, act, exp, mx, my);
    end
  endtask

  function automatic int f_r(int x, int y, int m);
    case (m)
      4: return (x*x + y*y) & 255;
      5: return (x + y) & 255;
      6: return (x*x - y*y) & 255;
      7: return ((x > y) ? x : y) & 255;
      default: return x & 255;
    endcase
  endfunction
  function automatic int f_g(int x, int y, int m);
    case (m)
      1: return (x + y) & 255;
      2: return (x * y) & 255;
      4: return (x*x + y*y) & 255;
      5: return (x - y) & 255;
      6: return (x*x - y*y) & 255;
      7: return ((x > y) ? x : y) & 255;
      default: return y & 255;
    endcase
  endfunction
  function automatic int f_b(int x, int y, int m);
    case (m)
      1: return (x + y) & 255;
      2: return (x * y) & 255;
      3: return 0;
      4: return (x*x + y*y) & 255;
      6: return (x*x - y*y) & 255;
      7: return ((x > y) ? x : y) & 255;
      default: return (x ^ y) & 255;
    endcase
  endfunction

  function automatic string tag(int m, bit st);
    if (st) return "R6";
    case (m)
      0, 3: return "R7";
      1, 2: return "R8";
      4, 6: return "R9";
      default: return "R10";
    endcase
  endfunction

  initial begin
    void'($urandom(32'd7315));
    repeat (3) @(negedge clk);
    chk("R1 x", int'(px_x), 0);
    chk("R1 y", int'(px_y), 0);
    chk("R1 valid", int'(pix_valid), 0);
    chk("R1 fs", int'(frame_start), 0);
    chk("R1 colour", int'({red, grn, blu}), 0);
    rst_n = 1;
    while (frames < 9 && cyc < 150000) begin
      @(negedge clk);
      cyc++;
      chk(pix_en ? "R2 x" : "R3 x", int'(px_x), mx);
      chk(pix_en ? "R2 y" : "R3 y", int'(px_y), my);
      chk("R5 valid", int'(pix_valid), ev);
      chk("R4 frame_start", int'(frame_start), efs);
      chk({tag(emode, stale), " red"}, int'(red), er);
      chk({tag(emode, stale), " grn"}, int'(grn), eg);
      chk({tag(emode, stale), " blu"}, int'(blu), eb);
      pix_en = ($urandom % 8) != 0;
      if (mx == H-1 && my == V-1) mode_sel = 3'(plan);
      else mode_sel = 3'($urandom % 8);
      efs = 0;
      ev = pix_en;
      if (pix_en) begin
        er = f_r(mx, my, mmode);
        eg = f_g(mx, my, mmode);
        eb = f_b(mx, my, mmode);
        emode = mmode;
        stale = (int'(mode_sel) != mmode);
        if (mx == H-1) begin
          mx = 0;
          if (my == V-1) begin
            my = 0; efs = 1; mmode = int'(mode_sel);
            plan = (plan + 1) % 8; frames++;
          end else my++;
        end else mx++;
      end
    end
    if (cyc >= 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d frames", frames, 9);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule